// File: doc/BRIEF.md
# Direct-mapped write-through cache controller

This block sits between a processor and main memory and keeps a small, fast copy of recently read memory blocks. Storage is organised as 32 lines of 64 bytes. A 20-bit byte address selects exactly one line through its middle bits. The line holds a block when its stored tag matches the upper address bits and its valid flag is set. Read hits are answered from local storage one cycle after the request is taken. A read miss fetches the whole 16-word block from memory, records the block's tag, marks the line valid and then returns the requested word.

Every processor write goes to memory as a single word write. When the written block is also held in a line, the cached word is updated at the same time. A write to a block that is not held leaves the line storage as it was, so writes never allocate a line. An external device that writes memory directly reports each block it overwrites on a snoop input. If that block is held, its line is marked invalid.

The processor side handles one request at a time. A request is taken only while the controller is idle. The stall output is high while a memory transfer is in progress, and a one-cycle ready pulse marks the end of every read and every write. The memory side uses a word-wide request/acknowledge handshake.

Top module: `wt_cache_ctrl`

## Requirements
- R1: After reset every line is invalid, so the first read of any address is a miss. While reset is held and in the first idle cycle after it, `cpu_ready`, `cpu_stall` and `mem_req` are low.
- R2: The address splits into tag = bits [19:11], line index = bits [10:6], word select = bits [5:2] and byte bits [1:0], which are ignored. Block n uses line n mod 32, so reading block n+32 replaces block n and a later read of block n misses.
- R3: For a read whose tag matches a valid line, `cpu_ready` is high in the cycle after the request is taken and carries the stored word. No memory transaction takes place, and `cpu_stall` stays low. `cpu_ready` is always a pulse one cycle long.
- R4: A read miss makes 16 memory reads, in ascending order, at the block base plus 4·k for k = 0 to 15. `mem_req`, `mem_addr` and `mem_we` stay stable until `mem_ack`. `cpu_stall` is high during the fetch, the requested word is returned with `cpu_ready`, and the line is then valid for that block.
- R5: A write to a cached block makes exactly one memory write (`mem_we`=1) of `cpu_wdata` to the address with bits [1:0] cleared. It also updates the cached word, so a later read hit returns the new value.
- R6: A write to a block that is not cached makes exactly one memory write and changes no line. A later read of that block misses, and the block that was already in that line still hits.
- R7: A pulse on `dma_wr_valid` whose address bits [19:6] name a cached block clears that line, so the next read of the block misses and returns the current memory contents. A pulse naming a block that is not cached leaves every line as it was.
- R8: When a snoop invalidates a line in the same cycle that a processor request to that line is taken, the request is handled as a miss. A read fetches all 16 words, and a write leaves the cache unchanged.
- R9: A snoop naming the block that is being fetched during a read miss leaves the line invalid at the end of the fetch, so the next read of that block misses again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_req | input | 1 | Processor request strobe, taken only while idle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 20 | Processor byte address |
| cpu_wdata | input | 32 | Processor write word |
| cpu_rdata | output | 32 | Read word, valid with cpu_ready |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_stall | output | 1 | High while a memory transfer is in progress |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 20 | Word-aligned memory byte address |
| mem_wdata | output | 32 | Memory write word |
| mem_rdata | input | 32 | Memory read word, valid with mem_ack |
| mem_ack | input | 1 | Memory completion, one cycle per word |
| dma_wr_valid | input | 1 | Snoop pulse: an external write hit a memory block |
| dma_wr_addr | input | 20 | Byte address inside the overwritten block |

## Verification
The bench builds the block with its default geometry: 32 lines of 64 bytes, 4-byte words and 20-bit addresses. Random addresses are limited to four tags and eight line indices, so conflict evictions, write misses onto occupied lines and repeated hits occur often. The memory model answers after 0 to 2 wait cycles. Directed cases place a snoop in the same cycle as a request and in the middle of a fetch, which are the only ways to reach the collision and mid-fetch invalidation paths.

// File: rtl/wtc_pkg.sv
// Shared types for the write-through cache controller.
package wtc_pkg;

    // Controller sequencing states.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_WRITE = 2'd2,
        ST_RESP  = 2'd3
    } wtc_state_e;

endpackage

// File: rtl/wtc_tag_store.sv
// Tag and valid-flag array, one entry per line.
// Gives the combinational lookup of one line, a fill write port and a snoop
// invalidate port. A fill on the same line in the same cycle takes priority
// over an invalidate, because the fill already carries the snoop outcome in
// fill_valid. Tags are not reset; only the valid flags are.
module wtc_tag_store #(
    parameter int LINES = 32,
    parameter int TAG_W = 9,
    parameter int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    output logic [TAG_W-1:0] lk_tag,
    output logic             lk_valid,
    input  logic             fill_we,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             fill_valid,
    input  logic             inv_req,
    input  logic [IDX_W-1:0] inv_idx,
    input  logic [TAG_W-1:0] inv_tag,
    output logic             inv_hit
);

    logic [TAG_W-1:0] tag_q [LINES];
    logic [LINES-1:0] valid_q;
    logic             inv_apply;

    // Lookup and snoop match.
    always_comb begin
        lk_tag    = tag_q[lk_idx];
        lk_valid  = valid_q[lk_idx];
        inv_hit   = inv_req && valid_q[inv_idx] && (tag_q[inv_idx] == inv_tag);
        inv_apply = inv_hit && !(fill_we && (fill_idx == inv_idx));
    end

    // Valid flags: cleared by reset, set or cleared by fills, cleared by snoops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            if (fill_we)
                valid_q[fill_idx] <= fill_valid;
            if (inv_apply)
                valid_q[inv_idx] <= 1'b0;
        end
    end

    // Tag array written on every fill.
    always_ff @(posedge clk) begin
        if (fill_we)
            tag_q[fill_idx] <= fill_tag;
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (valid_q == '0));

    a_r7_snoop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        inv_apply |=> !valid_q[$past(inv_idx)]);

endmodule

// File: rtl/wtc_data_store.sv
// Word storage for all lines, organised as line index by word select.
// One combinational read port and one synchronous write port. The contents
// are not reset; the valid flags decide whether a word is meaningful.
module wtc_data_store #(
    parameter int LINES  = 32,
    parameter int WPL    = 16,
    parameter int DATA_W = 32,
    parameter int IDX_W  = $clog2(LINES),
    parameter int WSEL_W = $clog2(WPL)
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [WSEL_W-1:0] rd_wsel,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WSEL_W-1:0] wr_wsel,
    input  logic [DATA_W-1:0] wr_data
);

    localparam int DEPTH = LINES * WPL;

    logic [DATA_W-1:0] word_q [DEPTH];

    // Read the addressed word.
    always_comb rd_data = word_q[{rd_idx, rd_wsel}];

    // Write one word.
    always_ff @(posedge clk) begin
        if (wr_en)
            word_q[{wr_idx, wr_wsel}] <= wr_data;
    end

endmodule

// File: rtl/wtc_ctrl.sv
// Request sequencer of the cache controller.
// Decides hit or miss in the idle cycle that takes a request. It runs
// line fetches and write-through transfers on the memory port, and it
// tracks a snoop that names the block being fetched. Assumes that the
// processor raises cpu_req only while the controller is idle. Requests in
// other states are ignored.
module wtc_ctrl
    import wtc_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int TAG_W  = 9,
    parameter int IDX_W  = 5,
    parameter int OFF_W  = 6,
    parameter int WSEL_W = 4,
    parameter int BYTE_W = 2,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              cpu_stall,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    input  logic              dma_wr_valid,
    input  logic [ADDR_W-1:0] dma_wr_addr,
    output logic [IDX_W-1:0]  lk_idx,
    input  logic [TAG_W-1:0]  lk_tag,
    input  logic              lk_valid,
    input  logic              inv_hit,
    output logic              fill_we,
    output logic [IDX_W-1:0]  fill_idx,
    output logic [TAG_W-1:0]  fill_tag,
    output logic              fill_valid,
    output logic [IDX_W-1:0]  ds_rd_idx,
    output logic [WSEL_W-1:0] ds_rd_wsel,
    input  logic [DATA_W-1:0] ds_rd_data,
    output logic              ds_wr_en,
    output logic [IDX_W-1:0]  ds_wr_idx,
    output logic [WSEL_W-1:0] ds_wr_wsel,
    output logic [DATA_W-1:0] ds_wr_data
);

    localparam logic [WSEL_W-1:0] LAST_WORD = WSEL_W'((1 << WSEL_W) - 1);
    localparam logic [ADDR_W-1:0] WORD_MASK = ~ADDR_W'((1 << BYTE_W) - 1);

    wtc_state_e        state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic [WSEL_W-1:0] cnt_q;
    logic              poison_q;

    logic [TAG_W-1:0]  c_tag, q_tag;
    logic [IDX_W-1:0]  c_idx, q_idx, d_idx;
    logic [WSEL_W-1:0] c_wsel, q_wsel;
    logic              accept, clash, hit, in_fill, fill_ack, dma_on_fill;

    // Address field extraction and hit decision.
    always_comb begin
        c_tag       = cpu_addr[ADDR_W-1 -: TAG_W];
        c_idx       = cpu_addr[OFF_W +: IDX_W];
        c_wsel      = cpu_addr[BYTE_W +: WSEL_W];
        q_tag       = addr_q[ADDR_W-1 -: TAG_W];
        q_idx       = addr_q[OFF_W +: IDX_W];
        q_wsel      = addr_q[BYTE_W +: WSEL_W];
        d_idx       = dma_wr_addr[OFF_W +: IDX_W];
        accept      = (state_q == ST_IDLE) && cpu_req;
        clash       = inv_hit && (d_idx == c_idx);
        hit         = lk_valid && (lk_tag == c_tag) && !clash;
        in_fill     = (state_q == ST_FILL);
        fill_ack    = in_fill && mem_ack;
        dma_on_fill = dma_wr_valid && ((dma_wr_addr >> OFF_W) == (addr_q >> OFF_W));
    end

    // Tag lookup, fill port and data store port steering.
    always_comb begin
        lk_idx     = c_idx;
        fill_we    = fill_ack && (cnt_q == LAST_WORD);
        fill_idx   = q_idx;
        fill_tag   = q_tag;
        fill_valid = !(poison_q || dma_on_fill);
        ds_rd_idx  = c_idx;
        ds_rd_wsel = c_wsel;
        ds_wr_en   = (accept && cpu_we && hit) || fill_ack;
        ds_wr_idx  = in_fill ? q_idx : c_idx;
        ds_wr_wsel = in_fill ? cnt_q : c_wsel;
        ds_wr_data = in_fill ? mem_rdata : cpu_wdata;
    end

    // Memory port and processor status outputs.
    always_comb begin
        mem_req   = in_fill || (state_q == ST_WRITE);
        mem_we    = (state_q == ST_WRITE);
        mem_addr  = in_fill ? {q_tag, q_idx, cnt_q, BYTE_W'(0)} : (addr_q & WORD_MASK);
        mem_wdata = wdata_q;
        cpu_rdata = rdata_q;
        cpu_ready = (state_q == ST_RESP);
        cpu_stall = in_fill || (state_q == ST_WRITE);
    end

    // Request sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            addr_q   <= '0;
            wdata_q  <= '0;
            rdata_q  <= '0;
            cnt_q    <= '0;
            poison_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        addr_q   <= cpu_addr;
                        wdata_q  <= cpu_wdata;
                        cnt_q    <= '0;
                        poison_q <= 1'b0;
                        if (cpu_we) begin
                            state_q <= ST_WRITE;
                        end else if (hit) begin
                            rdata_q <= ds_rd_data;
                            state_q <= ST_RESP;
                        end else begin
                            state_q <= ST_FILL;
                        end
                    end
                end
                ST_FILL: begin
                    if (dma_on_fill)
                        poison_q <= 1'b1;
                    if (mem_ack) begin
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == q_wsel)
                            rdata_q <= mem_rdata;
                        if (cnt_q == LAST_WORD)
                            state_q <= ST_RESP;
                    end
                end
                ST_WRITE: begin
                    if (mem_ack)
                        state_q <= ST_RESP;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    a_r3_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    a_r3_hit_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !cpu_we && hit) |=> (cpu_ready && !cpu_stall));

    a_r4_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    a_r5_single_write: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack) |=> (!mem_req && cpu_ready));

    a_r6_write_goes_out: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cpu_we) |=> (mem_req && mem_we));

    a_r8_clash_misses: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !cpu_we && clash) |=> (cpu_stall && !mem_we));

endmodule

// File: rtl/wt_cache_ctrl.sv
// Direct-mapped write-through cache controller, top level.
// Derives the address field widths from the geometry parameters and joins
// the sequencer to the tag and data arrays. Assumes that LINES, LINE_BYTES
// and WORD_BYTES are powers of two and that the address covers at least
// one tag bit.
module wt_cache_ctrl #(
    parameter int ADDR_W     = 20,
    parameter int LINES      = 32,
    parameter int LINE_BYTES = 64,
    parameter int WORD_BYTES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cpu_req,
    input  logic                    cpu_we,
    input  logic [ADDR_W-1:0]       cpu_addr,
    input  logic [8*WORD_BYTES-1:0] cpu_wdata,
    output logic [8*WORD_BYTES-1:0] cpu_rdata,
    output logic                    cpu_ready,
    output logic                    cpu_stall,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [8*WORD_BYTES-1:0] mem_wdata,
    input  logic [8*WORD_BYTES-1:0] mem_rdata,
    input  logic                    mem_ack,
    input  logic                    dma_wr_valid,
    input  logic [ADDR_W-1:0]       dma_wr_addr
);

    localparam int DATA_W = 8 * WORD_BYTES;
    localparam int IDX_W  = $clog2(LINES);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int BYTE_W = $clog2(WORD_BYTES);
    localparam int WPL    = LINE_BYTES / WORD_BYTES;
    localparam int WSEL_W = $clog2(WPL);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;

    logic [IDX_W-1:0]  lk_idx, fill_idx, ds_rd_idx, ds_wr_idx;
    logic [TAG_W-1:0]  lk_tag, fill_tag;
    logic              lk_valid, inv_hit, fill_we, fill_valid, ds_wr_en;
    logic [WSEL_W-1:0] ds_rd_wsel, ds_wr_wsel;
    logic [DATA_W-1:0] ds_rd_data, ds_wr_data;

    wtc_ctrl #(
        .ADDR_W (ADDR_W), .TAG_W (TAG_W), .IDX_W (IDX_W), .OFF_W (OFF_W),
        .WSEL_W (WSEL_W), .BYTE_W (BYTE_W), .DATA_W (DATA_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_req      (cpu_req),
        .cpu_we       (cpu_we),
        .cpu_addr     (cpu_addr),
        .cpu_wdata    (cpu_wdata),
        .cpu_rdata    (cpu_rdata),
        .cpu_ready    (cpu_ready),
        .cpu_stall    (cpu_stall),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_rdata    (mem_rdata),
        .mem_ack      (mem_ack),
        .dma_wr_valid (dma_wr_valid),
        .dma_wr_addr  (dma_wr_addr),
        .lk_idx       (lk_idx),
        .lk_tag       (lk_tag),
        .lk_valid     (lk_valid),
        .inv_hit      (inv_hit),
        .fill_we      (fill_we),
        .fill_idx     (fill_idx),
        .fill_tag     (fill_tag),
        .fill_valid   (fill_valid),
        .ds_rd_idx    (ds_rd_idx),
        .ds_rd_wsel   (ds_rd_wsel),
        .ds_rd_data   (ds_rd_data),
        .ds_wr_en     (ds_wr_en),
        .ds_wr_idx    (ds_wr_idx),
        .ds_wr_wsel   (ds_wr_wsel),
        .ds_wr_data   (ds_wr_data)
    );

    wtc_tag_store #(
        .LINES (LINES), .TAG_W (TAG_W), .IDX_W (IDX_W)
    ) u_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_idx     (lk_idx),
        .lk_tag     (lk_tag),
        .lk_valid   (lk_valid),
        .fill_we    (fill_we),
        .fill_idx   (fill_idx),
        .fill_tag   (fill_tag),
        .fill_valid (fill_valid),
        .inv_req    (dma_wr_valid),
        .inv_idx    (dma_wr_addr[OFF_W +: IDX_W]),
        .inv_tag    (dma_wr_addr[ADDR_W-1 -: TAG_W]),
        .inv_hit    (inv_hit)
    );

    wtc_data_store #(
        .LINES (LINES), .WPL (WPL), .DATA_W (DATA_W), .IDX_W (IDX_W), .WSEL_W (WSEL_W)
    ) u_data (
        .clk     (clk),
        .rd_idx  (ds_rd_idx),
        .rd_wsel (ds_rd_wsel),
        .rd_data (ds_rd_data),
        .wr_en   (ds_wr_en),
        .wr_idx  (ds_wr_idx),
        .wr_wsel (ds_wr_wsel),
        .wr_data (ds_wr_data)
    );

endmodule

// File: tb/wt_cache_ctrl_bench.sv
// Bench for the write-through cache controller. It contains a behavioural
// memory with random wait states, a bench-side model of the tag and valid
// state, and directed cases followed by seeded random traffic.
module wt_cache_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [19:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_ready, cpu_stall;
    logic        mem_req, mem_we;
    logic [19:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic        dma_wr_valid = 1'b0;
    logic [19:0] dma_wr_addr = '0;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    wt_cache_ctrl u_wt_cache_ctrl (
        .clk (clk), .rst_n (rst_n),
        .cpu_req (cpu_req), .cpu_we (cpu_we), .cpu_addr (cpu_addr),
        .cpu_wdata (cpu_wdata), .cpu_rdata (cpu_rdata),
        .cpu_ready (cpu_ready), .cpu_stall (cpu_stall),
        .mem_req (mem_req), .mem_we (mem_we), .mem_addr (mem_addr),
        .mem_wdata (mem_wdata), .mem_rdata (mem_rdata), .mem_ack (mem_ack),
        .dma_wr_valid (dma_wr_valid), .dma_wr_addr (dma_wr_addr)
    );

    // Behavioural memory: written words are kept, the rest follow a pattern.
    logic [31:0] wmem [int];
    logic [19:0] log_addr [$];
    logic        log_we [$];
    int          lat_cnt = 0;
    int          lat_tgt = 0;

    function automatic logic [31:0] memval(logic [19:0] a);
        int k = int'(a[19:2]);
        if (wmem.exists(k)) return wmem[k];
        return (32'(k) * 32'h9E3779B1) ^ 32'hC0DE0000;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            lat_cnt <= 0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
            lat_cnt <= 0;
        end else if (mem_req) begin
            if (lat_cnt >= lat_tgt) begin
                mem_ack <= 1'b1;
                log_addr.push_back(mem_addr);
                log_we.push_back(mem_we);
                if (mem_we) wmem[int'(mem_addr[19:2])] = mem_wdata;
                else        mem_rdata <= memval(mem_addr);
                lat_tgt = $urandom_range(0, 2);
                lat_cnt <= 0;
            end else begin
                lat_cnt <= lat_cnt + 1;
            end
        end
    end

    // Bench-side record of which block each line holds.
    bit         ref_v [32];
    logic [8:0] ref_t [32];

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [19:0] mk(int tag, int idx, int w);
        return {9'(tag), 5'(idx), 4'(w), 2'b00};
    endfunction

    // External block write, optionally changing memory contents. Starts and ends at a negedge.
    task automatic dma_blk(logic [19:0] a, bit change);
        int idx = int'(a[10:6]);
        if (change)
            for (int k = 0; k < 16; k++) begin
                logic [19:0] wa = {a[19:6], 4'(k), 2'b00};
                wmem[int'(wa[19:2])] = memval(wa) ^ (32'hA5A50000 + 32'(k));
            end
        if (ref_v[idx] && ref_t[idx] == a[19:11]) ref_v[idx] = 1'b0;
        dma_wr_valid = 1'b1;
        dma_wr_addr  = {a[19:6], 6'h2A};
        @(negedge clk);
        dma_wr_valid = 1'b0;
    endtask

    // One processor access with full checking. Starts and ends at a negedge.
    task automatic do_op(bit we, logic [19:0] a, logic [31:0] wd, string extra,
                         bit clash_dma = 1'b0, bit mid_dma = 1'b0);
        int          idx = int'(a[10:6]);
        logic [8:0]  tg = a[19:11];
        logic [31:0] exp_rd = memval(a);
        logic [19:0] base = {a[19:6], 6'h00};
        bit          inv, exp_hit, ok;
        int          cyc;
        string       req;
        inv     = clash_dma && ref_v[idx] && ref_t[idx] == tg;
        exp_hit = ref_v[idx] && ref_t[idx] == tg && !inv;
        if (inv) ref_v[idx] = 1'b0;
        if (we) req = exp_hit ? "R5" : "R6";
        else    req = exp_hit ? "R3" : "R4";
        req = {req, " ", extra};
        log_addr.delete();
        log_we.delete();
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        if (clash_dma) begin
            dma_wr_valid = 1'b1;
            dma_wr_addr  = {a[19:6], 6'h15};
        end
        @(negedge clk);
        cpu_req = 1'b0;
        dma_wr_valid = 1'b0;
        cyc = 1;
        if (!we && exp_hit) begin
            chk(cpu_ready, req, "ready one cycle after hit", 64'(cpu_ready), 64'd1);
            chk(!cpu_stall, req, "no stall on hit", 64'(cpu_stall), 64'd0);
        end else begin
            chk(cpu_stall, req, "stall while transfer runs", 64'(cpu_stall), 64'd1);
        end
        while (!cpu_ready && cyc < 300) begin
            if (mid_dma && cyc == 3) begin
                dma_wr_valid = 1'b1;
                dma_wr_addr  = {a[19:6], 6'h07};
            end
            if (cyc == 4) dma_wr_valid = 1'b0;
            @(negedge clk);
            cyc++;
        end
        dma_wr_valid = 1'b0;
        chk(cpu_ready, req, "ready reached", 64'(cpu_ready), 64'd1);
        if (!we) chk(cpu_rdata == exp_rd, req, "read data", 64'(cpu_rdata), 64'(exp_rd));
        if (we) begin
            ok = (log_addr.size() == 1) && log_we[0] && (log_addr[0] == {a[19:2], 2'b00});
            chk(ok, req, "single memory write", 64'(log_addr.size()), 64'd1);
            chk(memval(a) == wd, req, "memory holds written word", 64'(memval(a)), 64'(wd));
        end else if (exp_hit) begin
            chk(log_addr.size() == 0, req, "no memory traffic on hit", 64'(log_addr.size()), 64'd0);
        end else begin
            chk(log_addr.size() == 16, req, "fetch length", 64'(log_addr.size()), 64'd16);
            ok = (log_addr.size() == 16);
            for (int k = 0; k < 16 && ok; k++)
                if (log_we[k] || log_addr[k] != base + 20'(4 * k)) ok = 1'b0;
            chk(ok, req, "fetch address order", 64'(log_addr.size() > 0 ? log_addr[0] : 20'h0), 64'(base));
        end
        @(negedge clk);
        chk(!cpu_ready, req, "ready lasts one cycle", 64'(cpu_ready), 64'd0);
        if (!we && !exp_hit) begin
            ref_v[idx] = !mid_dma;
            ref_t[idx] = tg;
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R4 watchdog expired: actual=hung expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 32; i++) ref_v[i] = 1'b0;
        repeat (3) @(negedge clk);
        chk(!cpu_ready && !cpu_stall && !mem_req, "R1", "outputs quiet in reset",
            {61'd0, cpu_ready, cpu_stall, mem_req}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!cpu_ready && !cpu_stall && !mem_req, "R1", "outputs quiet after reset",
            {61'd0, cpu_ready, cpu_stall, mem_req}, 64'd0);

        // R1 / R4: a cold read misses; R3: another word of the same block hits.
        do_op(1'b0, mk(0, 1, 3), '0, "R1 cold read");
        do_op(1'b0, mk(0, 1, 9), '0, "same block");
        // R2: block 33 evicts block 1 from line 1; block 1 then misses.
        do_op(1'b0, mk(1, 1, 0), '0, "R2 conflict fill");
        do_op(1'b0, mk(0, 1, 5), '0, "R2 evicted block");
        // R5: a write hit reaches memory and the cache.
        do_op(1'b1, mk(0, 1, 5), 32'hDEAD0001, "R5 write hit");
        do_op(1'b0, mk(0, 1, 5), '0, "R5 read back");
        // R6: a write miss on an occupied line keeps the occupant.
        do_op(1'b1, mk(2, 1, 4), 32'hBEEF0002, "R6 write miss");
        do_op(1'b0, mk(0, 1, 4), '0, "R6 occupant kept");
        do_op(1'b0, mk(2, 1, 4), '0, "R6 not allocated");
        // R7: a snoop on the cached block forces a refetch of new data.
        dma_blk(mk(2, 1, 0), 1'b1);
        do_op(1'b0, mk(2, 1, 7), '0, "R7 after snoop");
        dma_blk(mk(3, 1, 0), 1'b1);
        do_op(1'b0, mk(2, 1, 8), '0, "R7 unrelated snoop");
        // R8: a snoop in the request cycle turns the read into a miss.
        do_op(1'b0, mk(2, 1, 2), '0, "R8 clash read", 1'b1);
        do_op(1'b1, mk(2, 1, 2), 32'h12345678, "R8 clash write", 1'b1);
        do_op(1'b0, mk(2, 1, 2), '0, "R8 after clash write");
        // R9: a snoop during the fetch leaves the line invalid.
        do_op(1'b0, mk(0, 5, 1), '0, "R9 fetch with snoop", 1'b0, 1'b1);
        do_op(1'b0, mk(0, 5, 1), '0, "R9 line left invalid");

        // Seeded random traffic over a small address window.
        for (int n = 0; n < 400; n++) begin
            int          r = $urandom_range(0, 99);
            logic [19:0] a = {9'($urandom_range(0, 3)), 5'($urandom_range(0, 7)),
                              4'($urandom_range(0, 15)), 2'($urandom_range(0, 3))};
            if (r < 10)      dma_blk(a, 1'($urandom_range(0, 1)));
            else if (r < 15) do_op(1'($urandom_range(0, 1)), a, $urandom(), "R8 random clash", 1'b1);
            else if (r < 40) do_op(1'b1, a, $urandom(), "R2 random");
            else             do_op(1'b0, a, '0, "R2 random");
        end
        finish_run();
    end

endmodule